// File: doc/BRIEF.md
# Exception entry controller

This block holds the control state that a processor core rewrites when it enters a handler. A single-cycle request carries a major cause code, a subcode, the PC of the trapping instruction, its instruction word, a flag saying that a TLB refill is in progress, and a handler address that an interrupt controller has already chosen. In the same clock edge the block picks one of three entry paths: debug, refill or general. It then updates that path's saved-mode, return-address and cause state, and registers the PC of the handler to fetch from next.

The core's mode (privilege level, interrupt enable, direct/paged translation flags) lives here too, so the saved copies always reflect the mode at the moment of entry. The general handler base, the refill handler address and the vector spacing select are plain configuration inputs. Two simple load ports let the surrounding core rewrite the mode bits and the debug-state bit outside of entries.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset: cur_plv=0, cur_ie=0, cur_da=1, cur_pg=0, cur_datf=1, cur_datm=1, new_pc=0x1C000000, pc_valid=0, cause_err=0. Every saved, return, cause, bad-address and debug output is 0.
- R2: Supported causes (major code, hex): 00 interrupt, 01 to 07 page faults (03 is the fetch page-invalid), 08 address error, 0A to 10, 12, and 1A debug breakpoint. Major 08 accepts subcode 0 (fetch) or 1 (data). Every other supported major needs subcode 0. Any other combination sets cause_err for one cycle, keeps pc_valid low, and changes no other output.
- R3: All state updates happen on the edge that samples entry_valid. new_pc and pc_valid are valid after that edge. pc_valid is high only in the cycle after an accepted request.
- R4: Debug breakpoint (1A) sets dbg_bp_flag, sets dbg_code to 0x0C, copies entry_pc to dbg_ret, sets dbg_active, and targets entry_base + 0x480.
- R5: An interrupt (00) while dbg_active is 1 sets dbg_int_flag, copies entry_pc to dbg_ret, keeps dbg_active set, and targets entry_base + 0x480. It leaves dbg_bp_flag and dbg_code unchanged.
- R6: On a non-debug entry with major 0B, 0C, 0D, 0E, 0F, 10 or 12, bad_va takes entry_pc. Other causes leave it unchanged.
- R7: bad_insn takes entry_insn on every non-debug entry, except interrupt (00), fetch page-invalid (03) and fetch address error (08 with subcode 0).
- R8: A non-debug entry with entry_refill=1 copies cur_plv and cur_ie into rf_plv and rf_ie, sets cur_da=1 and cur_pg=0, and loads rf_ret with entry_pc shifted right by 2. It targets refill_base, and ret_pc and the status codes keep their values.
- R9: A non-debug entry with entry_refill=0 writes the major code to st_ecode and the subcode to st_esub. It copies cur_plv and cur_ie into sv_plv and sv_ie, and entry_pc into ret_pc.
- R10: A general non-interrupt entry targets entry_base when vec_sel=0, and entry_base + (major << (vec_sel+2)) otherwise. A non-debug interrupt targets int_target on both the refill and the general path.
- R11: A refill or general entry forces cur_plv=0 and cur_ie=0. A debug-path entry leaves all mode bits as they were.
- R12: mode_wr loads cur_plv, cur_ie, cur_da and cur_pg, and dbg_wr loads dbg_active. Both are ignored in any cycle where entry_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_valid | input | 1 | One-cycle entry request |
| entry_major | input | 6 | Major cause code |
| entry_sub | input | 9 | Cause subcode |
| entry_pc | input | PC_W | PC of the trapping instruction |
| entry_insn | input | 32 | Trapping instruction word |
| entry_refill | input | 1 | TLB refill in progress |
| int_target | input | PC_W | Handler address for interrupts |
| entry_base | input | PC_W | General handler base |
| refill_base | input | PC_W | Refill handler address |
| vec_sel | input | 3 | Vector spacing select |
| mode_wr | input | 1 | Load mode bits |
| mode_plv | input | 2 | Privilege level to load |
| mode_ie | input | 1 | Interrupt enable to load |
| mode_da | input | 1 | Direct-address bit to load |
| mode_pg | input | 1 | Paging bit to load |
| dbg_wr | input | 1 | Load debug-state bit |
| dbg_val | input | 1 | Debug-state value to load |
| new_pc | output | PC_W | Handler PC |
| pc_valid | output | 1 | new_pc was just updated |
| cause_err | output | 1 | Last request had an unsupported cause |
| cur_plv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Current interrupt enable |
| cur_da | output | 1 | Direct-address mode |
| cur_pg | output | 1 | Paged mode |
| cur_datf | output | 2 | Direct-mode fetch attribute |
| cur_datm | output | 2 | Direct-mode data attribute |
| sv_plv | output | 2 | Saved privilege level, general path |
| sv_ie | output | 1 | Saved interrupt enable, general path |
| rf_plv | output | 2 | Saved privilege level, refill path |
| rf_ie | output | 1 | Saved interrupt enable, refill path |
| ret_pc | output | PC_W | Return address, general path |
| rf_ret | output | PC_W | Return address shifted right by 2, refill path |
| dbg_ret | output | PC_W | Return address, debug path |
| st_ecode | output | 6 | Major code of the last general entry |
| st_esub | output | 9 | Subcode of the last general entry |
| bad_va | output | PC_W | Bad virtual address |
| bad_insn | output | 32 | Bad instruction word |
| dbg_active | output | 1 | Debug state |
| dbg_bp_flag | output | 1 | Breakpoint entry seen |
| dbg_int_flag | output | 1 | Interrupt entered while in debug |
| dbg_code | output | 6 | Debug cause code |

## Verification
The checker covers the properties that hold at every cycle. These are the one-cycle pc_valid pulse, the error response with stable state, the debug target and return address, the refill return-address shift with the DA/PG bits, and the clearing of privilege and interrupt enable on refill and general entries. The choice of which causes load bad_va and bad_insn, the vector offset arithmetic across all spacing selects, and the priority of entries over the load ports depend on long sequences of mixed requests. Only the bench's random runs, compared against its own model, exercise those.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam logic [5:0] EC_INT  = 6'h00;
    localparam logic [5:0] EC_PIF  = 6'h03;
    localparam logic [5:0] EC_PPI  = 6'h07;
    localparam logic [5:0] EC_ADR  = 6'h08;
    localparam logic [5:0] EC_BCE  = 6'h0A;
    localparam logic [5:0] EC_SYS  = 6'h0B;
    localparam logic [5:0] EC_SXD  = 6'h10;
    localparam logic [5:0] EC_FPE  = 6'h12;
    localparam logic [5:0] EC_DBP  = 6'h1A;

    localparam logic [8:0] SUB_FETCH = 9'd0;
    localparam logic [8:0] SUB_DATA  = 9'd1;

    localparam logic [5:0] DBG_BP_CODE = 6'h0C;

    typedef enum logic [1:0] {
        PATH_NONE    = 2'd0,
        PATH_DEBUG   = 2'd1,
        PATH_REFILL  = 2'd2,
        PATH_GENERAL = 2'd3
    } entry_path_e;

    typedef struct packed {
        logic [1:0] plv;
        logic       ie;
        logic       da;
        logic       pg;
        logic [1:0] datf;
        logic [1:0] datm;
    } mode_t;

    typedef struct packed {
        logic       active;
        logic       bp;
        logic       intr;
        logic [5:0] code;
    } dbg_t;

endpackage

// File: rtl/exc_cause_class.sv
module exc_cause_class
    import exc_entry_pkg::*;
(
    input  logic [5:0]  major,
    input  logic [8:0]  sub,
    input  logic        refill,
    input  logic        dbg_active,
    output logic        ok,
    output entry_path_e path,
    output logic        is_int,
    output logic        sets_badv,
    output logic        sets_badi
);

    logic major_known;

    always_comb begin
        major_known = (major <= EC_PPI) || (major == EC_ADR) ||
                      ((major >= EC_BCE) && (major <= EC_SXD)) ||
                      (major == EC_FPE) || (major == EC_DBP);
        if (major == EC_ADR) begin
            ok = (sub == SUB_FETCH) || (sub == SUB_DATA);
        end else begin
            ok = major_known && (sub == 9'd0);
        end

        is_int = (major == EC_INT);

        if (!ok) begin
            path = PATH_NONE;
        end else if ((major == EC_DBP) || (is_int && dbg_active)) begin
            path = PATH_DEBUG;
        end else if (refill) begin
            path = PATH_REFILL;
        end else begin
            path = PATH_GENERAL;
        end

        sets_badv = ((major >= EC_SYS) && (major <= EC_SXD)) || (major == EC_FPE);
        sets_badi = !is_int && (major != EC_PIF) &&
                    !((major == EC_ADR) && (sub == SUB_FETCH));
    end

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
    import exc_entry_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int DBG_OFF = 'h480
) (
    input  entry_path_e      path,
    input  logic             is_int,
    input  logic [5:0]       major,
    input  logic [PC_W-1:0]  entry_base,
    input  logic [PC_W-1:0]  refill_base,
    input  logic [PC_W-1:0]  int_target,
    input  logic [2:0]       vec_sel,
    output logic [PC_W-1:0]  target
);

    localparam logic [PC_W-1:0] DBG_OFF_W = PC_W'(DBG_OFF);

    logic [3:0]      shamt;
    logic [PC_W-1:0] vec_off;

    always_comb begin
        shamt   = {1'b0, vec_sel} + 4'd2;
        vec_off = (vec_sel == 3'd0) ? '0 : ({{(PC_W-6){1'b0}}, major} << shamt);
        unique case (path)
            PATH_DEBUG:   target = entry_base + DBG_OFF_W;
            PATH_REFILL:  target = is_int ? int_target : refill_base;
            PATH_GENERAL: target = is_int ? int_target : (entry_base + vec_off);
            default:      target = entry_base;
        endcase
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = PC_W'(32'h1C00_0000)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_valid,
    input  logic [5:0]      entry_major,
    input  logic [8:0]      entry_sub,
    input  logic [PC_W-1:0] entry_pc,
    input  logic [31:0]     entry_insn,
    input  logic            entry_refill,
    input  logic [PC_W-1:0] int_target,
    input  logic [PC_W-1:0] entry_base,
    input  logic [PC_W-1:0] refill_base,
    input  logic [2:0]      vec_sel,
    input  logic            mode_wr,
    input  logic [1:0]      mode_plv,
    input  logic            mode_ie,
    input  logic            mode_da,
    input  logic            mode_pg,
    input  logic            dbg_wr,
    input  logic            dbg_val,
    output logic [PC_W-1:0] new_pc,
    output logic            pc_valid,
    output logic            cause_err,
    output logic [1:0]      cur_plv,
    output logic            cur_ie,
    output logic            cur_da,
    output logic            cur_pg,
    output logic [1:0]      cur_datf,
    output logic [1:0]      cur_datm,
    output logic [1:0]      sv_plv,
    output logic            sv_ie,
    output logic [1:0]      rf_plv,
    output logic            rf_ie,
    output logic [PC_W-1:0] ret_pc,
    output logic [PC_W-1:0] rf_ret,
    output logic [PC_W-1:0] dbg_ret,
    output logic [5:0]      st_ecode,
    output logic [8:0]      st_esub,
    output logic [PC_W-1:0] bad_va,
    output logic [31:0]     bad_insn,
    output logic            dbg_active,
    output logic            dbg_bp_flag,
    output logic            dbg_int_flag,
    output logic [5:0]      dbg_code
);

    typedef struct packed {
        mode_t           mode;
        logic [1:0]      sv_plv;
        logic            sv_ie;
        logic [1:0]      rf_plv;
        logic            rf_ie;
        dbg_t            dbg;
        logic [5:0]      ecode;
        logic [8:0]      esub;
        logic [31:0]     badi;
        logic [PC_W-1:0] era;
        logic [PC_W-1:0] rf_era;
        logic [PC_W-1:0] dera;
        logic [PC_W-1:0] badv;
        logic [PC_W-1:0] npc;
        logic            vld;
        logic            err;
    } ctl_t;

    ctl_t st_d, st_q;

    logic            cls_ok;
    entry_path_e     cls_path;
    logic            cls_int;
    logic            cls_badv;
    logic            cls_badi;
    logic [PC_W-1:0] tgt_pc;

    exc_cause_class u_class (
        .major      (entry_major),
        .sub        (entry_sub),
        .refill     (entry_refill),
        .dbg_active (st_q.dbg.active),
        .ok         (cls_ok),
        .path       (cls_path),
        .is_int     (cls_int),
        .sets_badv  (cls_badv),
        .sets_badi  (cls_badi)
    );

    exc_target_calc #(.PC_W(PC_W)) u_target (
        .path        (cls_path),
        .is_int      (cls_int),
        .major       (entry_major),
        .entry_base  (entry_base),
        .refill_base (refill_base),
        .int_target  (int_target),
        .vec_sel     (vec_sel),
        .target      (tgt_pc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        if (entry_valid) begin
            if (!cls_ok) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.npc = tgt_pc;
                if (cls_path == PATH_DEBUG) begin
                    st_d.dera       = entry_pc;
                    st_d.dbg.active = 1'b1;
                    if (cls_int) begin
                        st_d.dbg.intr = 1'b1;
                    end else begin
                        st_d.dbg.bp   = 1'b1;
                        st_d.dbg.code = DBG_BP_CODE;
                    end
                end else begin
                    if (cls_badv) st_d.badv = entry_pc;
                    if (cls_badi) st_d.badi = entry_insn;
                    if (cls_path == PATH_REFILL) begin
                        st_d.rf_plv  = st_q.mode.plv;
                        st_d.rf_ie   = st_q.mode.ie;
                        st_d.mode.da = 1'b1;
                        st_d.mode.pg = 1'b0;
                        st_d.rf_era  = {2'b00, entry_pc[PC_W-1:2]};
                    end else begin
                        st_d.ecode  = entry_major;
                        st_d.esub   = entry_sub;
                        st_d.sv_plv = st_q.mode.plv;
                        st_d.sv_ie  = st_q.mode.ie;
                        st_d.era    = entry_pc;
                    end
                    st_d.mode.plv = 2'd0;
                    st_d.mode.ie  = 1'b0;
                end
            end
        end else begin
            if (mode_wr) begin
                st_d.mode.plv = mode_plv;
                st_d.mode.ie  = mode_ie;
                st_d.mode.da  = mode_da;
                st_d.mode.pg  = mode_pg;
            end
            if (dbg_wr) begin
                st_d.dbg.active = dbg_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mode.da   <= 1'b1;
            st_q.mode.datf <= 2'd1;
            st_q.mode.datm <= 2'd1;
            st_q.npc       <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign new_pc       = st_q.npc;
    assign pc_valid     = st_q.vld;
    assign cause_err    = st_q.err;
    assign cur_plv      = st_q.mode.plv;
    assign cur_ie       = st_q.mode.ie;
    assign cur_da       = st_q.mode.da;
    assign cur_pg       = st_q.mode.pg;
    assign cur_datf     = st_q.mode.datf;
    assign cur_datm     = st_q.mode.datm;
    assign sv_plv       = st_q.sv_plv;
    assign sv_ie        = st_q.sv_ie;
    assign rf_plv       = st_q.rf_plv;
    assign rf_ie        = st_q.rf_ie;
    assign ret_pc       = st_q.era;
    assign rf_ret       = st_q.rf_era;
    assign dbg_ret      = st_q.dera;
    assign st_ecode     = st_q.ecode;
    assign st_esub      = st_q.esub;
    assign bad_va       = st_q.badv;
    assign bad_insn     = st_q.badi;
    assign dbg_active   = st_q.dbg.active;
    assign dbg_bp_flag  = st_q.dbg.bp;
    assign dbg_int_flag = st_q.dbg.intr;
    assign dbg_code     = st_q.dbg.code;

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_entry_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            entry_valid,
    input logic [PC_W-1:0] entry_pc,
    input logic [PC_W-1:0] entry_base,
    input entry_path_e     path_sel,
    input logic            cls_ok,
    input logic            pc_valid,
    input logic            cause_err,
    input logic [PC_W-1:0] new_pc,
    input logic [1:0]      cur_plv,
    input logic            cur_ie,
    input logic            cur_da,
    input logic            cur_pg,
    input logic [PC_W-1:0] ret_pc,
    input logic [PC_W-1:0] rf_ret,
    input logic [PC_W-1:0] dbg_ret,
    input logic            dbg_active
);

    localparam logic [PC_W-1:0] DBG_OFF_W = PC_W'('h480);

    // R3: accepted request gives pc_valid in the next cycle only
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && cls_ok) |=> pc_valid);
    p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_valid |=> !pc_valid);

    // R2: unsupported cause flags an error and keeps state
    p_bad_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && !cls_ok) |=> (cause_err && !pc_valid && $stable(new_pc)
                                      && $stable(ret_pc) && $stable(cur_plv)));

    // R4: debug path target and return address
    p_debug_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && path_sel == PATH_DEBUG) |=>
            (dbg_active && dbg_ret == $past(entry_pc)
             && new_pc == $past(entry_base) + DBG_OFF_W));

    // R8: refill path return address and translation bits
    p_refill_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && path_sel == PATH_REFILL) |=>
            (cur_da && !cur_pg && rf_ret == ($past(entry_pc) >> 2)));

    // R9: general path return address
    p_general_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && path_sel == PATH_GENERAL) |=> (ret_pc == $past(entry_pc)));

    // R11: mode cleared on refill or general entry
    p_mode_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && (path_sel == PATH_REFILL || path_sel == PATH_GENERAL)) |=>
            (cur_plv == 2'd0 && !cur_ie));

endmodule

bind exc_entry_ctrl exc_entry_checker #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_valid (entry_valid),
    .entry_pc    (entry_pc),
    .entry_base  (entry_base),
    .path_sel    (cls_path),
    .cls_ok      (cls_ok),
    .pc_valid    (pc_valid),
    .cause_err   (cause_err),
    .new_pc      (new_pc),
    .cur_plv     (cur_plv),
    .cur_ie      (cur_ie),
    .cur_da      (cur_da),
    .cur_pg      (cur_pg),
    .ret_pc      (ret_pc),
    .rf_ret      (rf_ret),
    .dbg_ret     (dbg_ret),
    .dbg_active  (dbg_active)
);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_valid = 1'b0;
    logic [5:0]  entry_major = '0;
    logic [8:0]  entry_sub = '0;
    logic [31:0] entry_pc = '0;
    logic [31:0] entry_insn = '0;
    logic        entry_refill = 1'b0;
    logic [31:0] int_target = 32'h0000_8000;
    logic [31:0] entry_base = 32'h1000_0000;
    logic [31:0] refill_base = 32'h2000_0000;
    logic [2:0]  vec_sel = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_plv = '0;
    logic        mode_ie = 1'b0, mode_da = 1'b0, mode_pg = 1'b0;
    logic        dbg_wr = 1'b0, dbg_val = 1'b0;

    logic [31:0] new_pc, ret_pc, rf_ret, dbg_ret, bad_va, bad_insn;
    logic        pc_valid, cause_err, cur_ie, cur_da, cur_pg, sv_ie, rf_ie;
    logic [1:0]  cur_plv, cur_datf, cur_datm, sv_plv, rf_plv;
    logic [5:0]  st_ecode, dbg_code;
    logic [8:0]  st_esub;
    logic        dbg_active, dbg_bp_flag, dbg_int_flag;

    // expected state
    logic [31:0] e_npc, e_era, e_rfera, e_dera, e_badv, e_badi;
    logic        e_vld, e_err, e_ie, e_da, e_pg, e_svie, e_rfie, e_dst, e_dcl, e_dei;
    logic [1:0]  e_plv, e_svplv, e_rfplv;
    logic [5:0]  e_ecode, e_dcode;
    logic [8:0]  e_esub;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid), .entry_major(entry_major),
        .entry_sub(entry_sub), .entry_pc(entry_pc), .entry_insn(entry_insn),
        .entry_refill(entry_refill), .int_target(int_target), .entry_base(entry_base),
        .refill_base(refill_base), .vec_sel(vec_sel), .mode_wr(mode_wr),
        .mode_plv(mode_plv), .mode_ie(mode_ie), .mode_da(mode_da), .mode_pg(mode_pg),
        .dbg_wr(dbg_wr), .dbg_val(dbg_val), .new_pc(new_pc), .pc_valid(pc_valid),
        .cause_err(cause_err), .cur_plv(cur_plv), .cur_ie(cur_ie), .cur_da(cur_da),
        .cur_pg(cur_pg), .cur_datf(cur_datf), .cur_datm(cur_datm), .sv_plv(sv_plv),
        .sv_ie(sv_ie), .rf_plv(rf_plv), .rf_ie(rf_ie), .ret_pc(ret_pc), .rf_ret(rf_ret),
        .dbg_ret(dbg_ret), .st_ecode(st_ecode), .st_esub(st_esub), .bad_va(bad_va),
        .bad_insn(bad_insn), .dbg_active(dbg_active), .dbg_bp_flag(dbg_bp_flag),
        .dbg_int_flag(dbg_int_flag), .dbg_code(dbg_code)
    );

    function automatic bit f_ok(input logic [5:0] m, input logic [8:0] s);
        bit known;
        known = (m <= 6'h07) || (m == 6'h08) || (m >= 6'h0A && m <= 6'h10) ||
                (m == 6'h12) || (m == 6'h1A);
        if (m == 6'h08) return (s <= 9'd1);
        return known && (s == 9'd0);
    endfunction

    function automatic bit f_badv(input logic [5:0] m);
        return (m >= 6'h0B && m <= 6'h10) || (m == 6'h12);
    endfunction

    function automatic bit f_badi(input logic [5:0] m, input logic [8:0] s);
        return !(m == 6'h00 || m == 6'h03 || (m == 6'h08 && s == 9'd0));
    endfunction

    function automatic logic [31:0] f_general(input logic [5:0] m, input logic [2:0] v,
                                              input logic [31:0] base);
        if (v == 3'd0) return base;
        return base + (32'(m) << (32'(v) + 2));
    endfunction

    task automatic model_reset();
        e_npc = 32'h1C00_0000; e_vld = 0; e_err = 0;
        e_plv = 0; e_ie = 0; e_da = 1; e_pg = 0;
        e_svplv = 0; e_svie = 0; e_rfplv = 0; e_rfie = 0;
        e_era = 0; e_rfera = 0; e_dera = 0; e_badv = 0; e_badi = 0;
        e_ecode = 0; e_esub = 0; e_dst = 0; e_dcl = 0; e_dei = 0; e_dcode = 0;
    endtask

    task automatic model_step();
        bit is_int;
        e_vld = 0; e_err = 0;
        if (entry_valid) begin
            if (!f_ok(entry_major, entry_sub)) begin
                e_err = 1;
            end else begin
                e_vld = 1;
                is_int = (entry_major == 6'h00);
                if (entry_major == 6'h1A || (is_int && e_dst)) begin
                    e_dera = entry_pc;
                    if (is_int) e_dei = 1;
                    else begin e_dcl = 1; e_dcode = 6'h0C; end
                    e_dst = 1;
                    e_npc = entry_base + 32'h480;
                end else begin
                    if (f_badv(entry_major)) e_badv = entry_pc;
                    if (f_badi(entry_major, entry_sub)) e_badi = entry_insn;
                    if (entry_refill) begin
                        e_rfplv = e_plv; e_rfie = e_ie; e_da = 1; e_pg = 0;
                        e_rfera = entry_pc >> 2;
                        e_npc = is_int ? int_target : refill_base;
                    end else begin
                        e_ecode = entry_major; e_esub = entry_sub;
                        e_svplv = e_plv; e_svie = e_ie; e_era = entry_pc;
                        e_npc = is_int ? int_target : f_general(entry_major, vec_sel, entry_base);
                    end
                    e_plv = 0; e_ie = 0;
                end
            end
        end else begin
            if (mode_wr) begin e_plv = mode_plv; e_ie = mode_ie; e_da = mode_da; e_pg = mode_pg; end
            if (dbg_wr) e_dst = dbg_val;
        end
    endtask

    task automatic chk(input string tag, input string name, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, name, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "new_pc", new_pc, e_npc);
        chk(tag, "pc_valid", 32'(pc_valid), 32'(e_vld));
        chk(tag, "cause_err", 32'(cause_err), 32'(e_err));
        chk(tag, "mode", {25'd0, cur_plv, cur_ie, cur_da, cur_pg, 1'b0},
            {25'd0, e_plv, e_ie, e_da, e_pg, 1'b0});
        chk(tag, "datf_datm", {28'd0, cur_datf, cur_datm}, 32'h5);
        chk(tag, "saved", {26'd0, sv_plv, sv_ie, rf_plv, rf_ie}, {26'd0, e_svplv, e_svie, e_rfplv, e_rfie});
        chk(tag, "ret_pc", ret_pc, e_era);
        chk(tag, "rf_ret", rf_ret, e_rfera);
        chk(tag, "dbg_ret", dbg_ret, e_dera);
        chk(tag, "codes", {17'd0, st_ecode, st_esub}, {17'd0, e_ecode, e_esub});
        chk(tag, "bad_va", bad_va, e_badv);
        chk(tag, "bad_insn", bad_insn, e_badi);
        chk(tag, "dbg", {23'd0, dbg_active, dbg_bp_flag, dbg_int_flag, dbg_code},
            {23'd0, e_dst, e_dcl, e_dei, e_dcode});
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
        entry_valid = 0; mode_wr = 0; dbg_wr = 0;
    endtask

    task automatic req(input logic [5:0] m, input logic [8:0] s, input logic rf,
                       input logic [31:0] pc);
        entry_valid = 1; entry_major = m; entry_sub = s; entry_refill = rf;
        entry_pc = pc; entry_insn = pc ^ 32'hA5A5_0F0F;
    endtask

    task automatic set_mode(input logic [1:0] p, input logic i, input logic d, input logic g);
        mode_wr = 1; mode_plv = p; mode_ie = i; mode_da = d; mode_pg = g;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [5:0] sup [22];
        sup = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h0A,
                6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h10, 6'h12, 6'h1A, 6'h0B, 6'h00,
                6'h08, 6'h12};
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_all("R1");

        // R4: breakpoint with a non-zero mode must keep the mode (R11)
        set_mode(2'd3, 1, 0, 1); cycle("R12");
        req(6'h1A, 0, 0, 32'h0000_1234); cycle("R4");
        chk("R11", "plv_kept_on_debug", 32'(cur_plv), 32'd3);
        // R5: interrupt while in debug
        req(6'h00, 0, 0, 32'h0000_2000); cycle("R5");
        // leave debug state, interrupt goes to int_target on general path
        dbg_wr = 1; dbg_val = 0; cycle("R12");
        set_mode(2'd2, 1, 0, 1); cycle("R12");
        req(6'h00, 0, 0, 32'h0000_3000); cycle("R10");
        // general syscall with spacing select 3
        vec_sel = 3'd3; set_mode(2'd1, 1, 0, 1); cycle("R12");
        req(6'h0B, 0, 0, 32'h0000_4004); cycle("R6");
        chk("R10", "sys_target", new_pc, 32'h1000_0000 + (32'h0B << 5));
        chk("R9", "sv_plv", 32'(sv_plv), 32'd1);
        // fetch page-invalid leaves bad_insn and bad_va
        req(6'h03, 0, 0, 32'h0000_5008); cycle("R7");
        // fetch address error vs data address error
        req(6'h08, 0, 0, 32'h0000_6000); cycle("R7");
        req(6'h08, 1, 0, 32'h0000_6100); cycle("R7");
        // refill with non-zero mode
        set_mode(2'd3, 1, 0, 1); cycle("R12");
        req(6'h01, 0, 1, 32'h0000_700C); cycle("R8");
        chk("R8", "rf_ret_shift", rf_ret, 32'h0000_1C03);
        // refill interrupt goes to int_target
        req(6'h00, 0, 1, 32'h0000_7100); cycle("R10");
        // unsupported causes
        req(6'h09, 0, 0, 32'h0000_8000); cycle("R2");
        req(6'h08, 2, 0, 32'h0000_8004); cycle("R2");
        req(6'h0B, 5, 0, 32'h0000_8008); cycle("R2");
        // entry wins over load ports
        req(6'h0D, 0, 0, 32'h0000_9000); set_mode(2'd3, 1, 0, 1); dbg_wr = 1; dbg_val = 1;
        cycle("R12");
        // pulse ends after an idle cycle
        cycle("R3");
        chk("R3", "pc_valid_low", 32'(pc_valid), 32'd0);
        vec_sel = 3'd0;
        req(6'h12, 0, 0, 32'h0000_A000); cycle("R10");

        for (int i = 0; i < 3000; i++) begin
            int k;
            k = int'($urandom % 10);
            if (k == 0) set_mode(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            else if (k == 1) begin dbg_wr = 1; dbg_val = 1'($urandom); end
            else if (k >= 3) begin
                logic [5:0] m;
                logic [8:0] s;
                m = ($urandom % 8 == 0) ? 6'($urandom) : sup[$urandom % 22];
                s = (m == 6'h08) ? 9'($urandom % 2) : (($urandom % 10 == 0) ? 9'($urandom) : 9'd0);
                req(m, s, ($urandom % 3 == 0), $urandom);
                vec_sel = 3'($urandom);
                entry_base = $urandom & 32'hFFFF_F000;
                refill_base = $urandom;
                int_target = $urandom;
                if ($urandom % 6 == 0) set_mode(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
                if ($urandom % 6 == 0) begin dbg_wr = 1; dbg_val = 1'($urandom); end
            end
            cycle("R9");
        end
        finish_run();
    end

endmodule